// File: doc/BRIEF.md
# Pixel Shift and Mask Accelerator

This block is a register-mapped helper for placing packed 4-bit pixels at positions that do not fall on a word boundary. Software loads a word of pixels into the source register. It then writes a horizontal position to the count register. The block moves the word right by whole pixels. It keeps both halves of the result: the pixels that stay in the word, and the pixels pushed past its right edge, which are realigned to the top of a separate word so they can go into the next memory word. It also produces a transparency mask of the shifted word. In that mask every non-zero pixel becomes a field of all ones. A sprite merge then needs only an inversion, an AND and an OR.

A second, independent unit turns any written word into the same kind of mask. Software uses it for words it assembles itself, for example spill bits combined with the next shifted stripe. All results come from registers. A busy output tells software when a result is still settling.

Top module: `pixshift_accel`

## Requirements
- R1: After reset, every readable result reads zero: shifted word, shifted mask, spill word and generated mask. The source word and the count are also zero, and busy is low.
- R2: A write to index 0 loads a new source word and clears the count to zero. It does not start a shift, so the readable results keep their previous values.
- R3: A write to index 1 starts a shift. The shifted word (read at index 0) equals the source word moved right by four bit positions per count step, with zero pixels entering at the left.
- R4: Only bits 2..0 of a count write are used. Bits 31..3 have no effect, so a raw x coordinate can be written.
- R5: The spill word (read at index 3) holds the pixels pushed out on the right, placed at the top of the word with the rest zero. For a count of 2, source bits 7..0 appear at bits 31..24.
- R6: A write to index 4 feeds the mask generator. Its result (read at index 4) has each 4-bit field set to 0xF when the matching input pixel is non-zero, and to 0 otherwise. For example, 0x0407000F gives 0x0F0F000F.
- R7: The shifted mask (read at index 2) is the R6 mask function applied to the current shifted word.
- R8: Shifted word and spill are updated on the first clock edge after the edge that accepts the count write. The shifted mask is updated one edge later. The generated mask is updated one edge after its write. Busy is high from the accepting edge until the last pending result is updated.
- R9: Index 1 is write-only and reads as 0xFFFFFFFF. Indices 5 to 7 are unused and also read as 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 3 | Register index for reads and writes |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the register selected by reg_idx |
| busy | output | 1 | High while a shift or mask result is still settling |

## Verification
The checker watches several behaviours on every cycle:
- A completed shift loses no bits: shifted word and spill together, moved back left, give the source word.
- Each settled mask covers every set bit of the word it was made from.
- A count write always raises busy.
- A source write always leaves a zero count.
- Write-only and unused indices always read all ones.

The bench scenarios show the rest. These are:
- exact mask values, including the zero fields;
- masking of the upper count bits;
- the cycle in which each result appears;
- stale results that survive a source write without a count write.

// File: rtl/pxa_pkg.sv
package pxa_pkg;
  localparam int IDX_W     = 3;
  localparam int IDX_SRC   = 0;
  localparam int IDX_CNT   = 1;
  localparam int IDX_SMASK = 2;
  localparam int IDX_SPILL = 3;
  localparam int IDX_MGEN  = 4;

  typedef struct packed {
    logic ld_src;
    logic ld_cnt;
    logic ld_mgen;
  } pxa_wr_t;
endpackage

// File: rtl/pxa_masker.sv
module pxa_masker #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int NPIX = WORD_W / PIX_W;

  logic [WORD_W-1:0] mask_c;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    assign mask_c[p*PIX_W +: PIX_W] = {PIX_W{|din[p*PIX_W +: PIX_W]}};
  end

  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (en) dout <= mask_c;
  end
endmodule

// File: rtl/pxa_shifter.sv
module pxa_shifter #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 4,
  parameter int CNT_W  = $clog2(WORD_W / PIX_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_src,
  input  logic              ld_cnt,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] src_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              go_q,
  output logic              done_q,
  output logic [WORD_W-1:0] shifted_q,
  output logic [WORD_W-1:0] spill_q
);
  localparam int DBL_W = 2 * WORD_W;

  logic [DBL_W-1:0] wide_c;

  assign wide_c = {src_q, {WORD_W{1'b0}}} >> (PIX_W * int'(cnt_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      cnt_q <= '0;
      go_q  <= 1'b0;
    end else begin
      go_q <= ld_cnt;
      if (ld_src) begin
        src_q <= wdata;
        cnt_q <= '0;
      end else if (ld_cnt) begin
        cnt_q <= wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shifted_q <= '0;
      spill_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= go_q;
      if (go_q) begin
        shifted_q <= wide_c[DBL_W-1:WORD_W];
        spill_q   <= wide_c[WORD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pxa_regif.sv
module pxa_regif
  import pxa_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] shifted,
  input  logic [WORD_W-1:0] smask,
  input  logic [WORD_W-1:0] spill,
  input  logic [WORD_W-1:0] mgen,
  output pxa_wr_t           wr,
  output logic [WORD_W-1:0] rd_data
);
  always_comb begin
    wr.ld_src  = wr_en && (int'(reg_idx) == IDX_SRC);
    wr.ld_cnt  = wr_en && (int'(reg_idx) == IDX_CNT);
    wr.ld_mgen = wr_en && (int'(reg_idx) == IDX_MGEN);
  end

  always_comb begin
    case (int'(reg_idx))
      IDX_SRC:   rd_data = shifted;
      IDX_SMASK: rd_data = smask;
      IDX_SPILL: rd_data = spill;
      IDX_MGEN:  rd_data = mgen;
      default:   rd_data = '1;
    endcase
  end
endmodule

// File: rtl/pixshift_accel.sv
module pixshift_accel
  import pxa_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy
);
  localparam int CNT_W = $clog2(WORD_W / PIX_W);

  pxa_wr_t           wr;
  logic [WORD_W-1:0] src_q, shifted_q, spill_q, smask_q, mg_in_q, mgen_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              go_q, done_q, mg_v_q;

  pxa_regif #(.WORD_W(WORD_W)) u_regif (
    .reg_idx(reg_idx), .wr_en(wr_en), .shifted(shifted_q), .smask(smask_q),
    .spill(spill_q), .mgen(mgen_q), .wr(wr), .rd_data(rd_data)
  );

  pxa_shifter #(.WORD_W(WORD_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .ld_src(wr.ld_src), .ld_cnt(wr.ld_cnt),
    .wdata(wr_data), .src_q(src_q), .cnt_q(cnt_q), .go_q(go_q),
    .done_q(done_q), .shifted_q(shifted_q), .spill_q(spill_q)
  );

  pxa_masker #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_smask (
    .clk(clk), .rst(rst), .en(done_q), .din(shifted_q), .dout(smask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mg_in_q <= '0;
      mg_v_q  <= 1'b0;
    end else begin
      mg_v_q <= wr.ld_mgen;
      if (wr.ld_mgen) mg_in_q <= wr_data;
    end
  end

  pxa_masker #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_mgen (
    .clk(clk), .rst(rst), .en(mg_v_q), .din(mg_in_q), .dout(mgen_q)
  );

  assign busy = go_q | done_q | mg_v_q;
endmodule

// File: rtl/pxa_checker.sv
module pxa_checker #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 4,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              wr_en,
  input logic [WORD_W-1:0] rd_data,
  input logic              busy,
  input logic [WORD_W-1:0] src_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              go_q,
  input logic [WORD_W-1:0] shifted_q,
  input logic [WORD_W-1:0] spill_q,
  input logic [WORD_W-1:0] smask_q,
  input logic [WORD_W-1:0] mg_in_q,
  input logic [WORD_W-1:0] mgen_q
);
  // R3 / R5: shifted word and spill together lose no source bits
  a_r3_lossless_shift: assert property (@(posedge clk) disable iff (rst)
    go_q |=> (({shifted_q, spill_q} << (PIX_W * int'($past(cnt_q)))) ==
              {$past(src_q), {WORD_W{1'b0}}}));

  // R7: settled shifted mask covers every set bit of the shifted word
  a_r7_smask_covers: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ((smask_q & shifted_q) == shifted_q));

  // R6: settled generated mask covers every set bit of its input
  a_r6_mgen_covers: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ((mgen_q & mg_in_q) == mg_in_q));

  // R8: a count write always raises busy
  a_r8_busy_on_count: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == 3'd1) |=> busy);

  // R2: a source write leaves the count at zero
  a_r2_count_cleared: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == 3'd0) |=> (cnt_q == '0));

  // R9: write-only and unused indices read all ones
  a_r9_unused_ones: assert property (@(posedge clk) disable iff (rst)
    (reg_idx == 3'd1 || reg_idx > 3'd4) |-> (rd_data == {WORD_W{1'b1}}));
endmodule

bind pixshift_accel pxa_checker #(
  .WORD_W(WORD_W), .PIX_W(PIX_W), .CNT_W(CNT_W), .IDX_W(pxa_pkg::IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en), .rd_data(rd_data),
  .busy(busy), .src_q(src_q), .cnt_q(cnt_q), .go_q(go_q),
  .shifted_q(shifted_q), .spill_q(spill_q), .smask_q(smask_q),
  .mg_in_q(mg_in_q), .mgen_q(mgen_q)
);

// File: tb/pixshift_accel_tb_top.sv
`timescale 1ns/1ps
module pixshift_accel_tb_top;
  typedef struct {
    logic [2:0]  idx;
    logic [31:0] val;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  drv_idx = '0, mon_idx = '0;
  logic        mon_active = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        busy;
  logic [2:0]  bus_idx;
  int          n_checks = 0, n_fail = 0;
  exp_t        sb[$];
  logic [31:0] m_shift = '0, m_spill = '0, m_smask = '0, m_mgen = '0;

  always #2.5 clk = ~clk;
  assign bus_idx = mon_active ? mon_idx : drv_idx;

  pixshift_accel dut_i (
    .clk(clk), .rst(rst), .reg_idx(bus_idx), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .busy(busy)
  );

  function automatic logic [31:0] mask_of(input logic [31:0] x);
    logic [31:0] m = '0;
    for (int p = 0; p < 8; p++) m[p*4 +: 4] = (x[p*4 +: 4] != 0) ? 4'hF : 4'h0;
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] idx, input logic [31:0] val, input string req);
    exp_t e;
    e.idx = idx; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic drain();
    wait (sb.size() == 0 && !mon_active);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    drv_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_all(input string req);
    push(3'd0, m_shift, req);
    push(3'd3, m_spill, req);
    push(3'd2, m_smask, req);
    push(3'd4, m_mgen, req);
  endtask

  // monitor: pops an expected item, selects it, compares one cycle later
  initial begin
    exp_t cur;
    forever begin
      @(negedge clk);
      if (mon_active) begin
        check(cur.req, rd_data, cur.val);
        mon_active = 1'b0;
      end else if (sb.size() > 0) begin
        cur = sb.pop_front();
        mon_idx = cur.idx;
        mon_active = 1'b1;
      end
    end
  end

  task automatic do_shift(input logic [31:0] src, input logic [31:0] cnt, input string req);
    logic [63:0] w;
    wr(3'd0, src);
    wr(3'd1, cnt);
    check("R8 busy after count", {31'b0, busy}, 32'd1);
    @(negedge clk);
    check("R8 busy mask pending", {31'b0, busy}, 32'd1);
    @(negedge clk);
    check("R8 busy cleared", {31'b0, busy}, 32'd0);
    w = {src, 32'b0} >> (4 * int'(cnt[2:0]));
    m_shift = w[63:32]; m_spill = w[31:0]; m_smask = mask_of(m_shift);
    push_all(req);
    drain();
  endtask

  task automatic do_mgen(input logic [31:0] x, input logic [31:0] exp, input string req);
    wr(3'd4, x);
    check("R8 mgen busy", {31'b0, busy}, 32'd1);
    @(negedge clk);
    check("R8 mgen settled", {31'b0, busy}, 32'd0);
    m_mgen = exp;
    check("R6 model", mask_of(x), exp);
    push(3'd4, exp, req);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    check("R1 busy", {31'b0, busy}, 32'd0);
    push_all("R1 reset");
    push(3'd1, 32'hFFFFFFFF, "R9 idx1");
    drain();
    // R6 generated masks
    do_mgen(32'h00000000, 32'h00000000, "R6 zero");
    do_mgen(32'h00000001, 32'h0000000F, "R6 one");
    do_mgen(32'h0407000F, 32'h0F0F000F, "R6 mixed");
    do_mgen(32'h1234ABC0, 32'hFFFFFFF0, "R6 dense");
    // R3 R5 R7 shifts
    do_shift(32'h1234ABCD, 32'd2, "R3 R5 R7 count2");
    check("R5 spill example", m_spill, 32'hCD000000);
    do_shift(32'hF0000001, 32'd7, "R3 R5 count7");
    do_shift(32'h80000060, 32'd1, "R7 count1");
    // R4 upper count bits ignored
    do_shift(32'h89ABCDEF, 32'hFFFFFFF8, "R4 count0");
    do_shift(32'h89ABCDEF, 32'h00000013, "R4 count3");
    // R2 source write alone does not change results
    wr(3'd0, 32'h11111111);
    repeat (3) @(negedge clk);
    check("R2 no busy", {31'b0, busy}, 32'd0);
    push_all("R2 stale");
    drain();
    // R2 count cleared: next count write shifts the new word
    do_shift(32'h11111111, 32'd5, "R2 new word");
    // R9 unused reads
    push(3'd5, 32'hFFFFFFFF, "R9 idx5");
    push(3'd7, 32'hFFFFFFFF, "R9 idx7");
    drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule